// File: doc/BRIEF.md
# Block Edge Direction Classifier

This block examines one 8x8 tile of luma samples and picks one of five classes for it: flat, 0-degree, 45-degree, 90-degree or 135-degree. A deblocking stage further down uses that class to choose its smoothing kernel. A start strobe opens a tile. Sixty-four 8-bit samples then follow in raster order, each one marked by a valid bit. The samples may arrive with idle gaps between them.

Each accepted sample is compared with its left neighbour and with the sample directly above it. A comparison counts as a step when the difference, taken relative to the mean of the two samples, is larger than one quarter. The test uses only a shift and an add. Each horizontal step moves one signed counter up or down, and each vertical step moves a second signed counter. When the tile is complete, the magnitudes and signs of the two counters select the class. The class is reported with a one-cycle done pulse.

Top module: `edge_dir_classifier`

## Requirements
- R1: After reset, done_o is 0 and dir_o is 0. A start_i pulse clears both step counters to zero, so the result for a tile does not depend on earlier tiles.
- R2: The horizontal counter compares each sample with the sample to its left in the same row, computed as right minus left. This gives 7 pairs per row, and no pair is formed across a row boundary.
- R3: The vertical counter compares each sample with the sample directly above it in the same column, computed as lower minus upper. This gives 7 pairs per column.
- R4: Let d be the difference of a pair and s be the sum of its two samples. If 8*d > s, the counter goes up by 1. If 8*d < -s, the counter goes down by 1. Otherwise the counter does not change, and this includes the case where 8*|d| equals s exactly.
- R5: Each counter is a 7-bit signed value and always stays within -56 to +56.
- R6: Let the edge length threshold be 6. If neither |H| nor |V| exceeds 6, the code is 0 (flat). If only |H| exceeds 6, the code is 1 (0-degree). If only |V| exceeds 6, the code is 3 (90-degree).
- R7: If both |H| and |V| exceed 6, the code is 2 (45-degree) when H and V have the same sign, and 4 (135-degree) when their signs differ.
- R8: done_o goes high for exactly one cycle. That cycle is the one after the clock edge that accepts the 64th sample. dir_o carries the code in that cycle and keeps it until the next start_i.
- R9: A sample is ignored, with no effect on the counters, dir_o or done_o, in three cases: when it arrives with start_i, before the first start_i, or after the 64th sample of a tile. A cycle with pix_valid_i low only pauses the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new tile and clears the counters |
| pix_valid_i | input | 1 | pix_i carries a sample this cycle |
| pix_i | input | 8 | Luma sample, raster order |
| dir_o | output | 3 | Direction code (0 flat, 1 0-deg, 2 45-deg, 3 90-deg, 4 135-deg) |
| done_o | output | 1 | One-cycle pulse when dir_o is valid |

## Verification
Some properties are checked by assertions on every cycle:
- A start clears both counters.
- A counter moves by at most one step per cycle.
- The counters never leave the -56..+56 range.
- The counters hold still while no tile is open.
- done_o never lasts two cycles.
- The reported code is always legal.

Other behaviours only the bench scenarios can show, by comparing against an arithmetic model of the tile:
- Which neighbour each pair uses.
- The exact threshold boundary at 8*|d| = s.
- The direction of each sign.
- The class chosen for ramps, diagonals, geometric extremes and pseudo-random tiles.
- The done timing, both with and without idle gaps.

// File: rtl/edc_pkg.sv
package edc_pkg;
  typedef enum logic [2:0] {
    DIR_FLAT = 3'd0,
    DIR_H    = 3'd1,
    DIR_D45  = 3'd2,
    DIR_V    = 3'd3,
    DIR_D135 = 3'd4
  } dir_e;
endpackage

// File: rtl/edc_step_det.sv
module edc_step_det #(
  parameter int PIX_W     = 8,
  parameter int TAU_SHIFT = 3
) (
  input  logic             en_i,
  input  logic [PIX_W-1:0] cur_i,
  input  logic [PIX_W-1:0] ref_i,
  output logic             up_o,
  output logic             dn_o
);
  localparam int W = PIX_W + TAU_SHIFT + 2;

  logic signed [W-1:0] cur_e, ref_e, diff, scaled, sum;

  assign cur_e  = $signed({{(W-PIX_W){1'b0}}, cur_i});
  assign ref_e  = $signed({{(W-PIX_W){1'b0}}, ref_i});
  assign diff   = cur_e - ref_e;
  assign scaled = diff <<< TAU_SHIFT;
  assign sum    = cur_e + ref_e;

  // relative step against mean: 2^TAU_SHIFT*d vs sum (tau = 2/2^TAU_SHIFT)
  assign up_o = en_i && (scaled > sum);
  assign dn_o = en_i && ((-scaled) > sum);
endmodule

// File: rtl/edc_updown.sv
module edc_updown #(
  parameter int CNT_W = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    up_i,
  input  logic                    dn_i,
  output logic signed [CNT_W-1:0] cnt_o
);
  localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= '0;
    else if (clr_i)         cnt_o <= '0;
    else if (up_i && !dn_i) cnt_o <= cnt_o + ONE;
    else if (dn_i && !up_i) cnt_o <= cnt_o - ONE;
  end
endmodule

// File: rtl/edc_decide.sv
module edc_decide
  import edc_pkg::*;
#(
  parameter int CNT_W   = 7,
  parameter int MIN_LEN = 6
) (
  input  logic signed [CNT_W-1:0] h_i,
  input  logic signed [CNT_W-1:0] v_i,
  output dir_e                    dir_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(MIN_LEN);

  logic [CNT_W-1:0] mag_h, mag_v;
  logic             big_h, big_v, same_sign;

  assign mag_h     = h_i[CNT_W-1] ? CNT_W'(-h_i) : CNT_W'(h_i);
  assign mag_v     = v_i[CNT_W-1] ? CNT_W'(-v_i) : CNT_W'(v_i);
  assign big_h     = mag_h > LIM;
  assign big_v     = mag_v > LIM;
  assign same_sign = h_i[CNT_W-1] == v_i[CNT_W-1];

  always_comb begin
    unique case ({big_h, big_v})
      2'b00:   dir_o = DIR_FLAT;
      2'b10:   dir_o = DIR_H;
      2'b01:   dir_o = DIR_V;
      default: dir_o = same_sign ? DIR_D45 : DIR_D135;
    endcase
  end
endmodule

// File: rtl/edge_dir_classifier.sv
module edge_dir_classifier
  import edc_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int BLK       = 8,
  parameter int TAU_SHIFT = 3,
  parameter int MIN_LEN   = 6,
  parameter int CNT_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [2:0]       dir_o,
  output logic             done_o
);
  localparam int POS_W = (BLK > 1) ? $clog2(BLK) : 1;
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(BLK - 1);
  localparam logic [POS_W-1:0] POS_ONE  = POS_W'(1);

  logic             busy_q, done_q;
  logic [POS_W-1:0] col_q, row_q;
  logic [PIX_W-1:0] left_q;
  logic [PIX_W-1:0] line_q [BLK];
  logic             accept, last;
  logic             h_up, h_dn, v_up, v_dn;
  logic signed [CNT_W-1:0] h_cnt, v_cnt;
  dir_e             dir;

  assign accept = busy_q && pix_valid_i && !start_i;
  assign last   = accept && (col_q == POS_LAST) && (row_q == POS_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
    end else begin
      done_q <= last;
      if (start_i) begin
        busy_q <= 1'b1;
        col_q  <= '0;
        row_q  <= '0;
      end else if (accept) begin
        if (last) busy_q <= 1'b0;
        if (col_q == POS_LAST) begin
          col_q <= '0;
          row_q <= row_q + POS_ONE;
        end else begin
          col_q <= col_q + POS_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     left_q <= '0;
    else if (accept) left_q <= pix_i;
  end

  // one-line delay: entry BLK-1 holds the sample directly above
  for (genvar g = 0; g < BLK; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     line_q[g] <= '0;
      else if (accept) line_q[g] <= (g == 0) ? pix_i : line_q[(g == 0) ? 0 : g-1];
    end
  end

  edc_step_det #(.PIX_W(PIX_W), .TAU_SHIFT(TAU_SHIFT)) u_det_h (
    .en_i  (accept && (col_q != '0)),
    .cur_i (pix_i),
    .ref_i (left_q),
    .up_o  (h_up),
    .dn_o  (h_dn)
  );

  edc_step_det #(.PIX_W(PIX_W), .TAU_SHIFT(TAU_SHIFT)) u_det_v (
    .en_i  (accept && (row_q != '0)),
    .cur_i (pix_i),
    .ref_i (line_q[BLK-1]),
    .up_o  (v_up),
    .dn_o  (v_dn)
  );

  edc_updown #(.CNT_W(CNT_W)) u_cnt_h (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (start_i),
    .up_i  (h_up),  .dn_i   (h_dn),   .cnt_o (h_cnt)
  );

  edc_updown #(.CNT_W(CNT_W)) u_cnt_v (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (start_i),
    .up_i  (v_up),  .dn_i   (v_dn),   .cnt_o (v_cnt)
  );

  edc_decide #(.CNT_W(CNT_W), .MIN_LEN(MIN_LEN)) u_decide (
    .h_i   (h_cnt),
    .v_i   (v_cnt),
    .dir_o (dir)
  );

  assign dir_o  = 3'(dir);
  assign done_o = done_q;
endmodule

// File: rtl/edc_checker.sv
module edc_checker #(
  parameter int CNT_W = 7,
  parameter int BLK   = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    busy_q,
  input logic signed [CNT_W-1:0] h_cnt,
  input logic signed [CNT_W-1:0] v_cnt,
  input logic [2:0]              dir_o,
  input logic                    done_o
);
  localparam logic signed [CNT_W-1:0] MAXC = CNT_W'(BLK * (BLK - 1));
  localparam logic signed [CNT_W-1:0] ONE  = CNT_W'(1);

  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (h_cnt == '0) && (v_cnt == '0));

  p_unit_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (h_cnt == $past(h_cnt)) || (h_cnt == $past(h_cnt) + ONE) || (h_cnt == $past(h_cnt) - ONE));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cnt <= MAXC) && (h_cnt >= -MAXC) && (v_cnt <= MAXC) && (v_cnt >= -MAXC));

  p_code_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dir_o <= 3'd4));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(h_cnt) && $stable(v_cnt));
endmodule

bind edge_dir_classifier edc_checker #(.CNT_W(CNT_W), .BLK(BLK)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_q  (busy_q),
  .h_cnt   (h_cnt),
  .v_cnt   (v_cnt),
  .dir_o   (dir_o),
  .done_o  (done_o)
);

// File: tb/edge_dir_classifier_tb.sv
module edge_dir_classifier_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       pix_valid_i = 1'b0;
  logic [7:0] pix_i = '0;
  logic [2:0] dir_o;
  logic       done_o;

  int n_chk = 0;
  int n_err = 0;
  int pix [64];
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  edge_dir_classifier u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .start_i (start_i),
    .pix_valid_i (pix_valid_i), .pix_i (pix_i),
    .dir_o (dir_o), .done_o (done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step(input int a, input int b);
    int d = a - b;
    if (8 * d > a + b) return 1;
    if (8 * d < -(a + b)) return -1;
    return 0;
  endfunction

  function automatic int model_code();
    int h = 0, v = 0;
    bit bh, bv;
    for (int r = 0; r < 8; r++)
      for (int c = 1; c < 8; c++) h += step(pix[r*8+c], pix[r*8+c-1]);
    for (int r = 1; r < 8; r++)
      for (int c = 0; c < 8; c++) v += step(pix[r*8+c], pix[(r-1)*8+c]);
    bh = (h > 6) || (h < -6);
    bv = (v > 6) || (v < -6);
    if (!bh && !bv) return 0;
    if (bh && !bv) return 1;
    if (!bh && bv) return 3;
    return ((h > 0) == (v > 0)) ? 2 : 4;
  endfunction

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF);
  endfunction

  task automatic fill(input int pat);
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        int x;
        case (pat)
          0: x = 128;
          1: x = 10 + 30 * c;
          2: x = 10 + 30 * r;
          3: x = 4 * (r + c) + 1;
          4: x = 4 * ((7 - r) + c) + 1;
          5: x = (c % 2) ? 9 : 7;
          6: x = (c % 2) ? 10 : 7;
          7: x = 1 << c;
          8: x = 128 >> r;
          9: x = 220 - 30 * c;
          10: x = 0;
          11: x = rnd();
          default: x = 100 + (rnd() % 40) + 6 * ((pat % 2) ? c : r);
        endcase
        pix[r*8+c] = x;
      end
  endtask

  task automatic run_block(input bit gaps, input string req);
    int exp = model_code();
    @(negedge clk);
    start_i = 1'b1; pix_valid_i = 1'b1; pix_i = 8'hFF;  // ignored with start (R9)
    @(negedge clk);
    start_i = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (gaps && (i % 5 == 2)) begin
        pix_valid_i = 1'b0; pix_i = 8'h00;
        @(negedge clk);
      end
      pix_valid_i = 1'b1; pix_i = 8'(pix[i]);
      if (i == 63) check(done_o == 1'b0, "R8 early done", int'(done_o), 0);
      @(negedge clk);
    end
    pix_valid_i = 1'b0;
    check(done_o == 1'b1, "R8 done after 64th", int'(done_o), 1);
    check(int'(dir_o) == exp, req, int'(dir_o), exp);
    @(negedge clk);
    check(done_o == 1'b0, "R8 single pulse", int'(done_o), 0);
    check(int'(dir_o) == exp, "R8 code held", int'(dir_o), exp);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    check(dir_o == 3'd0, "R1 reset code", int'(dir_o), 0);
    rst_ni = 1'b1;
    // samples before any start are ignored (R9)
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      pix_valid_i = 1'b1; pix_i = 8'((i % 2) ? 250 : 5);
    end
    @(negedge clk);
    pix_valid_i = 1'b0;
    check(done_o == 1'b0, "R9 pre-start done", int'(done_o), 0);
    check(dir_o == 3'd0, "R9 pre-start code", int'(dir_o), 0);

    fill(0);  run_block(1'b0, "R6 flat tile");
    fill(1);  run_block(1'b0, "R2 R6 rising row ramp");
    fill(9);  run_block(1'b1, "R2 falling row ramp");
    fill(2);  run_block(1'b0, "R3 R6 column ramp");
    fill(3);  run_block(1'b1, "R7 45 diagonal");
    // post-tile samples ignored (R9)
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      pix_valid_i = 1'b1; pix_i = 8'((i % 2) ? 250 : 3);
      if (i > 0) check(done_o == 1'b0, "R9 post-tile done", int'(done_o), 0);
    end
    @(negedge clk);
    pix_valid_i = 1'b0;
    check(dir_o == 3'd2, "R9 post-tile code", int'(dir_o), 2);
    fill(4);  run_block(1'b0, "R7 135 diagonal");
    fill(5);  run_block(1'b0, "R4 equal boundary no step");
    fill(6);  run_block(1'b1, "R4 above boundary steps");
    fill(7);  run_block(1'b0, "R5 row max count");
    fill(8);  run_block(1'b0, "R5 column min count");
    fill(10); run_block(1'b0, "R1 cleared after extremes");
    for (int k = 0; k < 40; k++) begin
      fill(11 + (k % 3));
      run_block(k[0], "R6 R7 random tile");
    end
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule